// File: doc/BRIEF.md
# Pixel Output Shifter with Gated Display Clock

This block sits between a tile fetcher and a clocked column-driver panel. At the start of a line and then once every eight advancing cycles, it loads two 8-bit plane registers from the tile planes the fetcher holds at that moment. It then presents one 2-bit pixel per cycle, most significant bit first. The panel has no notion of scrolling. Horizontal fine scroll and the window's start column both come from withholding display-clock edges. Pixels that leave the shifter while the clock is withheld never enter the panel.

The display clock is produced as an enable, `dclk_en`, and is qualified with the main clock. A sprite stall freezes the shifter and suppresses the clock. A window request cuts off the running group and holds the clock off for an opening group. After that group it reloads the planes and carries on. Once 159 pixels have been clocked, the block raises a latch pulse for one cycle. The panel then captures its 159 stages together with the live pixel as 160 columns. A behavioural model of that panel is part of the block, and its captured image is brought out for checking.

Top module: `pix_out_shifter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pix_data`, `dclk_en`, `lat` and every bit of `panel_image` are 0.
- R2: A cycle with `line_start` high loads the planes. From the next cycle, `pix_data` = {`tile_hi`[7-n], `tile_lo`[7-n]} for the n-th advancing cycle of the group. After 8 advancing cycles the planes reload from the current tile inputs.
- R3: In the first `fine_scroll` advancing cycles of a line, `dclk_en` stays low.
- R4: Exactly 159 `dclk_en` cycles occur per line, whatever the scroll, stalls and window.
- R5: `lat` is high for exactly one cycle: the cycle right after the one that carries the 159th clocked pixel. `dclk_en` is low in that cycle.
- R6: After the latch, column c of `panel_image` (bits 2c+1:2c, value {hi,lo}) holds the c-th clocked pixel for c = 0..158. Column 159 holds `pix_data` from the latch cycle.
- R7: With the same tile data, a line with fine scroll s yields an image whose column c equals column c+s of the image with scroll 0.
- R8: While `sprite_stall` is high, `dclk_en` is low, `pix_data` holds, and neither the scroll nor the clocked count advances.
- R9: A window request while running suppresses `dclk_en` in the request cycle and in the 6 following non-stalled cycles. The planes then reload from the tile inputs and the line resumes.
- R10: A window request that arrives during a sprite stall is held. It takes effect in the first non-stalled cycle.
- R11: A window request while no line is active has no effect: `dclk_en` stays low, `panel_image` is unchanged, and the next line runs as if no request had been made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low reset |
| line_start | input | 1 | Pulse that starts a line's output phase |
| win_start | input | 1 | Pulse requesting a window restart |
| sprite_stall | input | 1 | Level; freezes shifting and display clock |
| fine_scroll | input | 3 | Pixels to drop at line start, sampled on `line_start` |
| tile_lo | input | 8 | Low plane of the most recently fetched tile |
| tile_hi | input | 8 | High plane of the most recently fetched tile |
| pix_data | output | 2 | Pixel on the panel data pins, {hi,lo} |
| dclk_en | output | 1 | Display clock enable; panel shifts at the clock edge while high |
| lat | output | 1 | One-cycle line latch pulse |
| panel_image | output | 320 | Latched 160-column image of the panel model, 2 bits per column |

## Verification
A sprite stall and a window request can land in the same cycle. This contest decides whether the opening group starts at once or later. The bench raises `win_start` inside a stall window, both while fine scroll is still dropping pixels and after it is done. A behavioural model predicts every cycle's pixel, clock enable and latch. The request must wait out the stall and then produce the full opening gap, and the line must still close with exactly 159 clock cycles and the predicted image.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_WOPEN = 2'd2,
      ST_LATCH = 2'd3
   } pxs_state_e;
endpackage

// File: rtl/pxs_timing.sv
module pxs_timing
   import pxs_pkg::*;
#(
   parameter int GROUP    = 8,
   parameter int CLOCKED  = 159,
   parameter int WIN_HOLD = 6,
   parameter int SCROLL_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_start,
   input  logic                win_start,
   input  logic                sprite_stall,
   input  logic [SCROLL_W-1:0] fine_scroll,
   output logic                load,
   output logic                shift,
   output logic                dclk_en,
   output logic                lat
);
   localparam int GW = (GROUP > 1) ? $clog2(GROUP) : 1;
   localparam int CW = $clog2(CLOCKED + 1);
   localparam int WW = (WIN_HOLD > 1) ? $clog2(WIN_HOLD) : 1;

   pxs_state_e          state;
   logic [GW-1:0]       grp;
   logic [SCROLL_W-1:0] skip;
   logic [CW-1:0]       ncl;
   logic [WW-1:0]       wcnt;
   logic                pend;

   logic wreq, run_go, adv, grp_last, wop_done;

   always_comb begin
      wreq     = win_start | pend;
      run_go   = (state == ST_RUN) && !sprite_stall;
      adv      = run_go && !wreq;
      grp_last = (grp == GW'(GROUP - 1));
      wop_done = (state == ST_WOPEN) && !sprite_stall && (wcnt == WW'(WIN_HOLD - 1));
      dclk_en  = adv && (skip == '0);
      load     = line_start | (adv && grp_last) | wop_done;
      shift    = adv && !grp_last;
      lat      = (state == ST_LATCH);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         grp   <= '0;
         skip  <= '0;
         ncl   <= '0;
         wcnt  <= '0;
         pend  <= 1'b0;
      end else if (line_start) begin
         state <= ST_RUN;
         grp   <= '0;
         skip  <= fine_scroll;
         ncl   <= '0;
         wcnt  <= '0;
         pend  <= 1'b0;
      end else begin
         unique case (state)
            ST_RUN: begin
               if (sprite_stall) begin
                  if (win_start) pend <= 1'b1;
               end else if (wreq) begin
                  pend  <= 1'b0;
                  wcnt  <= '0;
                  state <= ST_WOPEN;
               end else begin
                  grp <= grp_last ? '0 : grp + GW'(1);
                  if (skip != '0) begin
                     skip <= skip - SCROLL_W'(1);
                  end else begin
                     ncl <= ncl + CW'(1);
                     if (ncl == CW'(CLOCKED - 1)) state <= ST_LATCH;
                  end
               end
            end
            ST_WOPEN: begin
               if (!sprite_stall) begin
                  if (wop_done) begin
                     grp   <= '0;
                     state <= ST_RUN;
                  end else begin
                     wcnt <= wcnt + WW'(1);
                  end
               end
            end
            ST_LATCH: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pxs_planes.sv
module pxs_planes #(
   parameter int GROUP = 8,
   parameter int NPL   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 shift,
   input  logic [NPL*GROUP-1:0] tiles,
   output logic [NPL-1:0]       pix
);
   for (genvar p = 0; p < NPL; p++) begin : g_plane
      logic [GROUP-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      sr <= '0;
         else if (load)   sr <= tiles[p*GROUP +: GROUP];
         else if (shift)  sr <= {sr[GROUP-2:0], 1'b0};
      end
      assign pix[p] = sr[GROUP-1];
   end
endmodule

// File: rtl/pxs_panel.sv
module pxs_panel #(
   parameter int CLOCKED = 159,
   parameter int PW      = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        dclk_en,
   input  logic                        lat,
   input  logic [PW-1:0]               pix,
   output logic [(CLOCKED+1)*PW-1:0]   image
);
   localparam int COLS = CLOCKED + 1;

   logic [PW-1:0] stg [CLOCKED];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < CLOCKED; i++) stg[i] <= '0;
      end else if (dclk_en) begin
         for (int i = 0; i < CLOCKED - 1; i++) stg[i] <= stg[i+1];
         stg[CLOCKED-1] <= pix;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         image <= '0;
      end else if (lat) begin
         for (int i = 0; i < CLOCKED; i++) image[i*PW +: PW] <= stg[i];
         image[(COLS-1)*PW +: PW] <= pix;
      end
   end
endmodule

// File: rtl/pix_out_shifter.sv
module pix_out_shifter #(
   parameter int GROUP    = 8,
   parameter int CLOCKED  = 159,
   parameter int WIN_HOLD = 6,
   parameter int SCROLL_W = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          line_start,
   input  logic                          win_start,
   input  logic                          sprite_stall,
   input  logic [SCROLL_W-1:0]           fine_scroll,
   input  logic [GROUP-1:0]              tile_lo,
   input  logic [GROUP-1:0]              tile_hi,
   output logic [1:0]                    pix_data,
   output logic                          dclk_en,
   output logic                          lat,
   output logic [(CLOCKED+1)*2-1:0]      panel_image
);
   localparam int NPL = 2;

   if (GROUP < 2 || (GROUP & (GROUP - 1)) != 0) begin : g_bad_group
      $error("GROUP must be a power of two of at least 2");
   end
   if ((1 << SCROLL_W) > GROUP) begin : g_bad_scroll
      $error("fine scroll range must not exceed one group");
   end
   if (CLOCKED < 1 || WIN_HOLD < 1) begin : g_bad_counts
      $error("CLOCKED and WIN_HOLD must be positive");
   end

   logic load, shift;

   pxs_timing #(
      .GROUP(GROUP), .CLOCKED(CLOCKED), .WIN_HOLD(WIN_HOLD), .SCROLL_W(SCROLL_W)
   ) u_timing (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .win_start(win_start),
      .sprite_stall(sprite_stall), .fine_scroll(fine_scroll),
      .load(load), .shift(shift), .dclk_en(dclk_en), .lat(lat)
   );

   pxs_planes #(.GROUP(GROUP), .NPL(NPL)) u_planes (
      .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
      .tiles({tile_hi, tile_lo}), .pix(pix_data)
   );

   pxs_panel #(.CLOCKED(CLOCKED), .PW(NPL)) u_panel (
      .clk(clk), .rst_n(rst_n), .dclk_en(dclk_en), .lat(lat),
      .pix(pix_data), .image(panel_image)
   );
endmodule

// File: rtl/pxs_checker.sv
module pxs_checker #(
   parameter int CLOCKED = 159
) (
   input logic       clk,
   input logic       rst_n,
   input logic       line_start,
   input logic       win_start,
   input logic       sprite_stall,
   input logic       dclk_en,
   input logic       lat,
   input logic [1:0] pix_data
);
   localparam int SW = $clog2(CLOCKED + 2);
   logic [SW-1:0] seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          seen <= '0;
      else if (line_start) seen <= '0;
      else if (dclk_en)    seen <= seen + SW'(1);
   end

   AST_LAT_NO_DCLK: assert property (@(posedge clk) disable iff (!rst_n)
      lat |-> !dclk_en);                                         // R5
   AST_LAT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      lat |=> !lat);                                             // R5
   AST_LAT_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      lat |-> seen == SW'(CLOCKED));                             // R5
   AST_CLK_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
      (dclk_en && !line_start) |-> seen < SW'(CLOCKED));         // R4
   AST_STALL_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      sprite_stall |-> !dclk_en);                                // R8
   AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (sprite_stall && !line_start) |=> $stable(pix_data));      // R8
   AST_WIN_CUT: assert property (@(posedge clk) disable iff (!rst_n)
      win_start |-> !dclk_en);                                   // R9
endmodule

bind pix_out_shifter pxs_checker #(.CLOCKED(CLOCKED)) u_chk (
   .clk(clk), .rst_n(rst_n), .line_start(line_start), .win_start(win_start),
   .sprite_stall(sprite_stall), .dclk_en(dclk_en), .lat(lat), .pix_data(pix_data)
);

// File: tb/tb_pix_out_shifter.sv
module tb_pix_out_shifter;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic         rst_n, line_start, win_start, sprite_stall;
   logic [2:0]   fine_scroll;
   logic [7:0]   tile_lo, tile_hi;
   logic [1:0]   pix_data;
   logic         dclk_en, lat;
   logic [319:0] panel_image;

   pix_out_shifter dut (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .win_start(win_start),
      .sprite_stall(sprite_stall), .fine_scroll(fine_scroll),
      .tile_lo(tile_lo), .tile_hi(tile_hi), .pix_data(pix_data),
      .dclk_en(dclk_en), .lat(lat), .panel_image(panel_image)
   );

   int checks = 0, errors = 0;

   // behavioural reference: 0 idle, 1 running, 2 window opening, 3 latch
   int          m_state, m_grp, m_skip, m_ncl, m_wcnt, loads, dclk_seen;
   bit          m_pend, img_due;
   logic [1:0]  q[$];
   logic [1:0]  shown[$];
   logic [319:0] exp_img;
   logic [319:0] img_by_scroll [8];

   function automatic logic [7:0] pat_lo(int n);
      return 8'((n * 37 + 5) & 255);
   endfunction
   function automatic logic [7:0] pat_hi(int n);
      return 8'((n * 101 + 90) & 255);
   endfunction

   task automatic chk(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_img(logic [319:0] act, logic [319:0] exp, string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void m_load();
      q.delete();
      for (int b = 7; b >= 0; b--) q.push_back({tile_hi[b], tile_lo[b]});
      loads++;
   endfunction

   function automatic void m_shift();
      void'(q.pop_front());
      q.push_back(2'b00);
   endfunction

   // one clock cycle: called at a falling edge
   task automatic cyc(bit ls, bit ws, bit st);
      bit    wreq, e_dclk, e_lat;
      string tag;
      line_start   = ls;
      win_start    = ws;
      sprite_stall = st;
      tile_lo      = pat_lo(loads);
      tile_hi      = pat_hi(loads);
      #1;
      wreq   = ws | m_pend;
      e_dclk = (m_state == 1) && !st && !wreq && (m_skip == 0);
      e_lat  = (m_state == 3);
      if (m_state == 2)                 tag = "R9";
      else if (m_state == 1 && !st && wreq) tag = m_pend ? "R10" : "R9";
      else if (m_state == 1 && st)      tag = "R8";
      else if (m_state == 1 && m_skip > 0) tag = "R3";
      else if (m_state == 0 && ws)      tag = "R11";
      else                              tag = "R4";
      chk(pix_data === q[0], "R2 pix_data", pix_data, q[0]);
      chk(dclk_en === e_dclk, {tag, " dclk_en"}, dclk_en, e_dclk);
      chk(lat === e_lat, "R5 lat", lat, e_lat);
      if (img_due) begin
         chk_img(panel_image, exp_img, "R6 panel_image");
         img_due = 0;
      end
      if (dclk_en === 1'b1) dclk_seen++;
      // advance reference across the rising edge
      if (ls) begin
         m_state = 1; m_grp = 0; m_skip = fine_scroll; m_ncl = 0; m_wcnt = 0; m_pend = 0;
         shown.delete();
         m_load();
      end else begin
         case (m_state)
            1: begin
               if (st) begin
                  if (ws) m_pend = 1;
               end else if (wreq) begin
                  m_pend = 0; m_wcnt = 0; m_state = 2;
               end else begin
                  if (m_skip > 0) m_skip--;
                  else begin
                     shown.push_back(q[0]);
                     m_ncl++;
                  end
                  if (m_grp == 7) begin m_load(); m_grp = 0; end
                  else begin m_shift(); m_grp++; end
                  if (m_ncl == 159) m_state = 3;
               end
            end
            2: begin
               if (!st) begin
                  if (m_wcnt == 5) begin m_load(); m_grp = 0; m_state = 1; end
                  else m_wcnt++;
               end
            end
            3: begin
               for (int c = 0; c < 159; c++) exp_img[2*c +: 2] = shown[c];
               exp_img[318 +: 2] = q[0];
               img_due = 1;
               m_state = 0;
            end
            default: ;
         endcase
      end
      @(negedge clk);
   endtask

   task automatic run_line(int fs, int win_at, int st_from, int st_to);
      int i = 0;
      fine_scroll = 3'(fs);
      loads = 0;
      dclk_seen = 0;
      do begin
         cyc(i == 0, i == win_at, (i >= st_from) && (i <= st_to));
         i++;
      end while (m_state != 0 && i < 600);
      cyc(0, 0, 0);
      chk(dclk_seen == 159, "R4 clocked pixels per line", dclk_seen, 159);
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [319:0] held;
      bit ok;
      rst_n = 1'b0; line_start = 0; win_start = 0; sprite_stall = 0;
      fine_scroll = 0; tile_lo = 0; tile_hi = 0;
      m_state = 0; m_pend = 0; img_due = 0; loads = 0;
      for (int b = 0; b < 8; b++) q.push_back(2'b00);
      repeat (3) @(negedge clk);
      chk(pix_data === 2'b00, "R1 pix_data in reset", pix_data, 0);
      chk(dclk_en === 1'b0, "R1 dclk_en in reset", dclk_en, 0);
      chk(lat === 1'b0, "R1 lat in reset", lat, 0);
      chk_img(panel_image, '0, "R1 panel_image in reset");
      rst_n = 1'b1;
      cyc(0, 0, 0);

      // R7: every scroll value, plain lines
      for (int s = 0; s < 8; s++) begin
         run_line(s, -1, -1, -2);
         img_by_scroll[s] = panel_image;
      end
      for (int s = 1; s < 8; s++) begin
         ok = 1;
         for (int c = 0; c < 160 - s; c++)
            if (img_by_scroll[s][2*c +: 2] !== img_by_scroll[0][2*(c+s) +: 2]) ok = 0;
         chk(ok, "R7 scroll shifts image left", s, s);
      end

      // R8: sprite stalls mid line and during fine scroll
      run_line(5, -1, 2, 4);
      run_line(0, -1, 40, 47);
      // R9: window restarts, late and early, with scroll
      run_line(0, 60, -1, -2);
      run_line(3, 2, -1, -2);
      run_line(7, 150, 100, 103);
      // R10: window request falls inside a sprite stall
      run_line(0, 52, 50, 55);
      run_line(6, 3, 1, 4);
      run_line(2, 80, 80, 80);

      // R11: window request with no active line
      held = panel_image;
      dclk_seen = 0;
      for (int k = 0; k < 5; k++) cyc(0, 1, k == 2);
      chk(dclk_seen == 0, "R11 no clock from idle window request", dclk_seen, 0);
      chk_img(panel_image, held, "R11 image unchanged");
      run_line(0, -1, -1, -2);
      chk_img(panel_image, img_by_scroll[0], "R11 next line unaffected");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule